// File: doc/BRIEF.md
# Write Status Bit Generator

This block builds the word returned to a host read while a flash bank is busy with an internal program or erase. It takes each read strobe and address, along with the array word at that address and the state reported by the erase/program engine. From these it decides whether the read gets plain array data or a status word. A status word carries a polling bit (bit 7), a main toggle bit (bit 6) and a second toggle bit (bit 2).

The two banks are split at a parameterised word address. Only reads aimed at the bank running the operation return status; reads into the other bank return array data. This lets code keep running from one bank while the other is written. During an erase suspend, reads that hit the suspended sector report a fixed pattern plus a toggling bit 2. This lets software tell a suspended sector apart from a sector that is being actively erased.

The block also drives a ready/busy line in open-drain style: a pull-down enable that is asserted while an operation runs.

Top module: `wsg_status_gen`

## Requirements
- R1: A read strobe sampled high on a rising clock edge makes `rd_valid_o` high for the next cycle, with that read's word on `rd_data_o`. With no strobe, `rd_valid_o` is low the next cycle, and it is low out of reset.
- R2: The bank of an address is 1 when the address is at or above `BANK_SPLIT`, otherwise 0. A read returns `array_i` unchanged in three cases: no operation is active and the address is outside the suspended sector; the address is in the bank not named by `op_bank_i`; or an erase has completed, so erased words read their array value.
- R3: During an active program (`op_erase_i`=0), a read in the busy bank returns bit 7 as the inverse of bit 7 of `prog_data_i` and bit 2 as 1. All bits other than 7, 6 and 2 come from `array_i`.
- R4: During an active erase (`op_erase_i`=1), a read in the busy bank returns bit 7 as 0 and bit 2 from the second toggle state, which inverts after every such read.
- R5: Every program or erase status read returns bit 6 from the main toggle state, which inverts after the read. Reads that are not status reads leave it unchanged.
- R6: The sector of an address is `addr >> SECTOR_SHIFT`. When `susp_i` is 1 and the sector equals `susp_sector_i`, a read returns bit 7 = 1, bit 6 = 1 and bit 2 from the second toggle state, which then inverts. This takes precedence over R3 and R4.
- R7: A program started during erase suspend reports program status (R3, R5) for reads in its bank outside the suspended sector.
- R8: `ryby_oe_o` is 1 in the cycle after `active_i` is sampled high, and 0 in the cycle after it is sampled low. This includes a suspended erase with no program running.
- R9: `start_i` clears both toggle states. A status read in the same cycle as `start_i` reports both toggle bits as 0.
- R10: The two toggle states are independent. Bit 6 changes only on reads under R5, and bit 2 changes only on reads under R4 or R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse when the engine begins a program or erase |
| active_i | input | 1 | Program or erase currently running |
| op_erase_i | input | 1 | 1 = running operation is an erase, 0 = program |
| op_bank_i | input | 1 | Bank holding the running operation |
| susp_i | input | 1 | An erase is suspended |
| susp_sector_i | input | ADDR_W-SECTOR_SHIFT | Sector index of the suspended erase |
| prog_data_i | input | DATA_W | Latched program data |
| rd_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read word address |
| array_i | input | DATA_W | Array word at `rd_addr_i` |
| rd_valid_o | output | 1 | Read word valid |
| rd_data_o | output | DATA_W | Read word (array or status) |
| ryby_oe_o | output | 1 | Ready/busy pull-down enable (1 = busy) |

## Verification
The read word and `rd_valid_o` are due in the cycle that follows the clock edge where the strobe was sampled. The toggle states change at that same edge. `ryby_oe_o` follows `active_i` one edge later. The bench drives every input on the falling edge and advances a behavioural model on the rising edge. It compares the model against the outputs on the next falling edge, so each check samples exactly one register stage after its stimulus. The directed reads use the same timing to confirm toggle sequences, the precedence of the suspended sector, and clearing on start.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
   typedef enum logic [1:0] {
      RK_ARRAY = 2'd0,
      RK_PROG  = 2'd1,
      RK_ERASE = 2'd2,
      RK_SUSP  = 2'd3
   } rd_kind_e;

   localparam int BIT_POLL = 7;
   localparam int BIT_TGL  = 6;
   localparam int BIT_ALT  = 2;
endpackage

// File: rtl/wsg_classify.sv
module wsg_classify
   import wsg_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int SECTOR_SHIFT = 11,
   parameter int BANK_SPLIT   = 32'h40000,
   localparam int SECT_W      = ADDR_W - SECTOR_SHIFT
)(
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic              active_i,
   input  logic              op_erase_i,
   input  logic              op_bank_i,
   input  logic              susp_i,
   input  logic [SECT_W-1:0] susp_sector_i,
   output rd_kind_e          kind_o
);
   localparam bit SPLIT_POW2 = ((BANK_SPLIT & (BANK_SPLIT - 1)) == 0);
   localparam int SPLIT_LOG  = $clog2(BANK_SPLIT);

   logic              addr_hi;
   logic [SECT_W-1:0] sector;
   logic              in_busy_bank;
   logic              in_susp_sector;

   generate
      if (SPLIT_POW2) begin : g_split_bit
         assign addr_hi = |rd_addr_i[ADDR_W-1:SPLIT_LOG];
      end else begin : g_split_cmp
         assign addr_hi = (rd_addr_i >= ADDR_W'(BANK_SPLIT));
      end
   endgenerate

   assign sector         = rd_addr_i[ADDR_W-1:SECTOR_SHIFT];
   assign in_busy_bank   = (addr_hi == op_bank_i);
   assign in_susp_sector = susp_i && (sector == susp_sector_i);

   always_comb begin
      if (in_susp_sector)
         kind_o = RK_SUSP;
      else if (active_i && in_busy_bank)
         kind_o = op_erase_i ? RK_ERASE : RK_PROG;
      else
         kind_o = RK_ARRAY;
   end
endmodule

// File: rtl/wsg_toggle.sv
module wsg_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic flip6_i,
   input  logic flip2_i,
   output logic t6_o,
   output logic t2_o
);
   logic t6_q, t2_q;

   assign t6_o = start_i ? 1'b0 : t6_q;
   assign t2_o = start_i ? 1'b0 : t2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t6_q <= 1'b0;
         t2_q <= 1'b0;
      end else begin
         t6_q <= t6_o ^ flip6_i;
         t2_q <= t2_o ^ flip2_i;
      end
   end

   AST_T6_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (flip6_i && !start_i) |=> (t6_q != $past(t6_q)));   // R5
   AST_T6_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!flip6_i && !start_i) |=> $stable(t6_q));          // R10
   AST_T2_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!flip2_i && !start_i) |=> $stable(t2_q));          // R10
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !flip6_i && !flip2_i) |=> (!t6_q && !t2_q)); // R9
endmodule

// File: rtl/wsg_format.sv
module wsg_format
   import wsg_pkg::*;
#(
   parameter int DATA_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_i,
   input  rd_kind_e          kind_i,
   input  logic [DATA_W-1:0] array_i,
   input  logic              prog_bit_i,
   input  logic              t6_i,
   input  logic              t2_i,
   output logic              rd_valid_o,
   output logic [DATA_W-1:0] rd_data_o
);
   logic [DATA_W-1:0] word;

   always_comb begin
      word = array_i;
      unique case (kind_i)
         RK_PROG: begin
            word[BIT_POLL] = ~prog_bit_i;
            word[BIT_TGL]  = t6_i;
            word[BIT_ALT]  = 1'b1;
         end
         RK_ERASE: begin
            word[BIT_POLL] = 1'b0;
            word[BIT_TGL]  = t6_i;
            word[BIT_ALT]  = t2_i;
         end
         RK_SUSP: begin
            word[BIT_POLL] = 1'b1;
            word[BIT_TGL]  = 1'b1;
            word[BIT_ALT]  = t2_i;
         end
         default: word = array_i;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_o <= 1'b0;
         rd_data_o  <= '0;
      end else begin
         rd_valid_o <= rd_i;
         if (rd_i) rd_data_o <= word;
      end
   end

   AST_VALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> rd_valid_o);                                       // R1
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> !rd_valid_o);                                     // R1
   AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && kind_i == RK_ERASE) |=> !rd_data_o[BIT_POLL]);     // R4
   AST_SUSP_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && kind_i == RK_SUSP) |=> (rd_data_o[BIT_POLL] && rd_data_o[BIT_TGL])); // R6
endmodule

// File: rtl/wsg_status_gen.sv
module wsg_status_gen
   import wsg_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int DATA_W       = 16,
   parameter int SECTOR_SHIFT = 11,
   parameter int BANK_SPLIT   = 32'h40000,
   localparam int SECT_W      = ADDR_W - SECTOR_SHIFT
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              active_i,
   input  logic              op_erase_i,
   input  logic              op_bank_i,
   input  logic              susp_i,
   input  logic [SECT_W-1:0] susp_sector_i,
   input  logic [DATA_W-1:0] prog_data_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic [DATA_W-1:0] array_i,
   output logic              rd_valid_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              ryby_oe_o
);
   generate
      if (DATA_W < 8) begin : g_bad_data_w
         $error("DATA_W must hold the status bits (>= 8)");
      end
      if (ADDR_W > 30 || SECTOR_SHIFT < 1 || SECTOR_SHIFT >= ADDR_W) begin : g_bad_addr
         $error("ADDR_W / SECTOR_SHIFT out of range");
      end
      if (BANK_SPLIT <= 0 || BANK_SPLIT >= (1 << ADDR_W)) begin : g_bad_split
         $error("BANK_SPLIT must lie inside the address space");
      end
   endgenerate

   rd_kind_e kind;
   logic     t6, t2;
   logic     flip6, flip2;

   wsg_classify #(
      .ADDR_W(ADDR_W), .SECTOR_SHIFT(SECTOR_SHIFT), .BANK_SPLIT(BANK_SPLIT)
   ) u_classify (
      .rd_addr_i(rd_addr_i), .active_i(active_i), .op_erase_i(op_erase_i),
      .op_bank_i(op_bank_i), .susp_i(susp_i), .susp_sector_i(susp_sector_i),
      .kind_o(kind)
   );

   assign flip6 = rd_i && (kind == RK_PROG || kind == RK_ERASE);
   assign flip2 = rd_i && (kind == RK_ERASE || kind == RK_SUSP);

   wsg_toggle u_toggle (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .flip6_i(flip6), .flip2_i(flip2), .t6_o(t6), .t2_o(t2)
   );

   wsg_format #(.DATA_W(DATA_W)) u_format (
      .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .kind_i(kind),
      .array_i(array_i), .prog_bit_i(prog_data_i[BIT_POLL]),
      .t6_i(t6), .t2_i(t2), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ryby_oe_o <= 1'b0;
      else        ryby_oe_o <= active_i;
   end

   AST_BUSY_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      active_i |=> ryby_oe_o);                                   // R8
   AST_IDLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |=> !ryby_oe_o);                                 // R8
   AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !active_i && !susp_i) |=> (rd_data_o == $past(array_i))); // R2
endmodule

// File: tb/wsg_status_gen_tb.sv
`timescale 1ns/1ps
module wsg_status_gen_tb_top;
   localparam int AW = 20, DW = 16, SSH = 11, BSPLIT = 32'h40000;
   localparam int SW = AW - SSH;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 0, active = 0, op_erase = 0, op_bank = 0, susp = 0, rd = 0;
   logic [SW-1:0] susp_sector = '0;
   logic [DW-1:0] prog_data = '0, array_w = '0;
   logic [AW-1:0] rd_addr = '0;
   logic          rd_valid, ryby_oe;
   logic [DW-1:0] rd_data;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   wsg_status_gen #(.ADDR_W(AW), .DATA_W(DW), .SECTOR_SHIFT(SSH), .BANK_SPLIT(BSPLIT)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .active_i(active), .op_erase_i(op_erase),
      .op_bank_i(op_bank), .susp_i(susp), .susp_sector_i(susp_sector), .prog_data_i(prog_data),
      .rd_i(rd), .rd_addr_i(rd_addr), .array_i(array_w),
      .rd_valid_o(rd_valid), .rd_data_o(rd_data), .ryby_oe_o(ryby_oe)
   );

   function automatic logic [DW-1:0] arr_of(input logic [AW-1:0] a);
      return a[DW-1:0] ^ 16'h3C5A;
   endfunction

   function automatic logic [DW-1:0] put3(input logic [DW-1:0] w, input logic b7, b6, b2);
      logic [DW-1:0] r = w;
      r[7] = b7; r[6] = b6; r[2] = b2;
      return r;
   endfunction

   // behavioural reference model
   bit m_valid = 0, m_oe = 0, m_t6 = 0, m_t2 = 0;
   logic [DW-1:0] m_data = '0;
   string m_req = "R1";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid = 0; m_oe = 0; m_t6 = 0; m_t2 = 0; m_data = '0;
      end else begin
         bit t6e, t2e, f6, f2, hi;
         int sec;
         t6e = start ? 1'b0 : m_t6;
         t2e = start ? 1'b0 : m_t2;
         f6 = 0; f2 = 0;
         m_oe = active;
         m_valid = rd;
         if (rd) begin
            hi  = (int'(rd_addr) >= BSPLIT);
            sec = int'(rd_addr) >> SSH;
            if (susp && sec == int'(susp_sector)) begin
               m_data = put3(array_w, 1, 1, t2e); f2 = 1; m_req = "R6";
            end else if (active && hi == op_bank) begin
               if (op_erase) begin
                  m_data = put3(array_w, 0, t6e, t2e); f6 = 1; f2 = 1; m_req = "R4";
               end else begin
                  m_data = put3(array_w, ~prog_data[7], t6e, 1); f6 = 1; m_req = "R3";
               end
            end else begin
               m_data = array_w; m_req = "R2";
            end
         end
         m_t6 = t6e ^ f6;
         m_t2 = t2e ^ f2;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (ryby_oe !== m_oe) begin
            errors++; $display("FAIL R8 ryby_oe act=%b exp=%b", ryby_oe, m_oe);
         end
         checks++;
         if (rd_valid !== m_valid) begin
            errors++; $display("FAIL R1 rd_valid act=%b exp=%b", rd_valid, m_valid);
         end
         if (m_valid) begin
            checks++;
            if (rd_data !== m_data) begin
               errors++; $display("FAIL %s rd_data act=%h exp=%h", m_req, rd_data, m_data);
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++; $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   logic [DW-1:0] last;
   task automatic rd_at(input logic [AW-1:0] a, input bit with_start = 0);
      rd = 1; rd_addr = a; array_w = arr_of(a); start = with_start;
      @(negedge clk);
      rd = 0; start = 0;
      last = rd_data;
   endtask

   task automatic begin_op(input bit er, input bit bank);
      start = 1; active = 1; op_erase = er; op_bank = bank;
      @(negedge clk);
      start = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset valid", {15'b0, rd_valid}, 16'h0);
      chk("R8 reset ryby", {15'b0, ryby_oe}, 16'h0);
      rst_n = 1;
      @(negedge clk);

      // idle reads, both banks
      rd_at(20'h00123); chk("R2 idle bank0", last, arr_of(20'h00123));
      rd_at(20'h51234); chk("R2 idle bank1", last, arr_of(20'h51234));

      // program in bank 0
      prog_data = 16'h00A5;
      begin_op(0, 0);
      chk("R8 busy", {15'b0, ryby_oe}, 16'h1);
      rd_at(20'h00123); chk("R3 R5 prog rd1", last, put3(arr_of(20'h00123), 0, 0, 1));
      rd_at(20'h00123); chk("R5 prog rd2", last, put3(arr_of(20'h00123), 0, 1, 1));
      rd_at(20'h60010); chk("R2 other bank", last, arr_of(20'h60010));
      rd_at(20'h00124); chk("R5 prog rd3", last, put3(arr_of(20'h00124), 0, 0, 1));
      active = 0;
      @(negedge clk);
      chk("R8 idle", {15'b0, ryby_oe}, 16'h0);
      rd_at(20'h00123); chk("R2 after program", last, arr_of(20'h00123));

      // erase in bank 1, first read together with start
      op_erase = 1; op_bank = 1; active = 1;
      rd_at(20'h50010, 1); chk("R9 R4 start read", last, put3(arr_of(20'h50010), 0, 0, 0));
      rd_at(20'h50010); chk("R4 erase rd2", last, put3(arr_of(20'h50010), 0, 1, 1));
      rd_at(20'h50010); chk("R4 erase rd3", last, put3(arr_of(20'h50010), 0, 0, 0));

      // suspend erase of sector 0xA0
      active = 0; susp = 1; susp_sector = 9'h0A0;
      @(negedge clk);
      chk("R8 suspended ready", {15'b0, ryby_oe}, 16'h0);
      rd_at(20'h50010); chk("R6 susp rd1", last, put3(arr_of(20'h50010), 1, 1, 1));
      rd_at(20'h50020); chk("R6 susp rd2", last, put3(arr_of(20'h50020), 1, 1, 0));
      rd_at(20'h58000); chk("R2 non-susp sector", last, arr_of(20'h58000));

      // program during suspend in another sector of bank 1
      prog_data = 16'h0011;
      begin_op(0, 1);
      rd_at(20'h58000); chk("R7 prog in susp rd1", last, put3(arr_of(20'h58000), 1, 0, 1));
      rd_at(20'h50010); chk("R6 R10 susp during prog", last, put3(arr_of(20'h50010), 1, 1, 0));
      rd_at(20'h58000); chk("R7 R10 prog in susp rd2", last, put3(arr_of(20'h58000), 1, 1, 1));
      rd_at(20'h50010); chk("R10 susp bit2 flips", last, put3(arr_of(20'h50010), 1, 1, 1));
      active = 0; susp = 0;
      @(negedge clk);

      // randomised traffic checked against the model
      for (int i = 0; i < 600; i++) begin
         if (i % 12 == 0) begin
            int mode = $urandom_range(0, 3);
            active = (mode == 1 || mode == 2) || (mode == 3 && $urandom_range(0, 1) == 1);
            op_erase = (mode == 2);
            op_bank = $urandom_range(0, 1);
            susp = (mode == 3);
            susp_sector = SW'($urandom_range(0, (1 << SW) - 1));
            prog_data = DW'($urandom);
            start = active;
         end else begin
            start = 0;
         end
         rd = $urandom_range(0, 3) != 0;
         if ($urandom_range(0, 3) == 0) rd_addr = {susp_sector, 11'($urandom)};
         else rd_addr = AW'($urandom);
         array_w = arr_of(rd_addr);
         @(negedge clk);
      end
      rd = 0; start = 0;
      @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule